// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block is the status and write-protection logic of a serial flash memory that acts as an SPI slave in clock mode 0. It watches the chip-select, serial clock and serial data input with a fast system clock, shifts in one command per chip-select frame and carries out three commands: write enable, status read and status write. It keeps a write-enable latch, a lock bit that guards the sector protection settings, and it reports a busy flag supplied by the program and erase engines outside this block.

Every state change is held back until chip-select returns high. Only then does the block decide whether the frame was complete, whether the write-enable latch allowed it, and whether the write-protect pin blocks it. A completed status write can also request a global protect or a global unprotect of every sector. The request is a one-cycle pulse to an external protection array, and it is only issued while the lock bit was clear before the command.

Top module: `spiFlashStatusCtrl`

## Requirements
- R1: After reset the status byte reads 00h with the busy input low, `spiSoEn` is low and neither global pulse has fired.
- R2: Opcode 06h, completed before chip-select rises, sets the write-enable latch (status bit 1) at chip-select deassertion. A frame with fewer than 8 opcode bits, or with a complete opcode that is not one of 06h, 05h and 01h, leaves the latch unchanged. This holds also when the incomplete bits are the start of 01h.
- R3: After opcode 05h the status byte {lock, 0, 0, 0, 0, 0, write-enable latch, busy} is shifted out on `spiSo`, MSB first. `spiSi` is sampled on rising and `spiSo` is changed on falling serial clock edges. The byte repeats while the clock runs, and each repeat takes a fresh copy of the status, so a change on the busy input appears at the next byte boundary.
- R4: Opcode 01h with the latch set, followed by a full data byte, loads data bit 7 into the lock bit (status bit 7) and clears the latch when chip-select rises. Bytes after the first data byte are ignored.
- R5: Opcode 01h with the latch clear changes neither the lock bit nor the latch and fires no pulse.
- R6: Opcode 01h with the latch set but fewer than 8 data bits leaves the lock bit unchanged, fires no pulse and clears the latch.
- R7: While `wpN` is low, a status write that would clear a set lock bit is dropped entirely (no lock change, no pulse) and still clears the latch. Setting the lock bit under `wpN` low is allowed.
- R8: An accepted status write with data bits 5:2 equal to 1111 and a lock bit of 0 before the command gives a one-cycle `globalProtect` pulse. Bits 5:2 equal to 0000 under the same condition give a one-cycle `globalUnprotect` pulse. Any other pattern, or a lock bit of 1 before the command, gives no pulse. Bits 6, 1 and 0 have no effect.
- R9: `spiSoEn` is high only while chip-select is low, and global pulses occur only while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial interface |
| rstN | input | 1 | Active-low asynchronous reset |
| spiCsN | input | 1 | Active-low chip select |
| spiSck | input | 1 | Serial clock, idle low (mode 0) |
| spiSi | input | 1 | Serial data in, MSB first |
| wpN | input | 1 | Active-low write-protect pin |
| busyIn | input | 1 | Busy flag from the program and erase engines |
| spiSo | output | 1 | Serial data out |
| spiSoEn | output | 1 | Output enable for `spiSo`; low means high impedance |
| globalProtect | output | 1 | One-cycle request to protect all sectors |
| globalUnprotect | output | 1 | One-cycle request to unprotect all sectors |

## Verification
The bench sweeps every combination of prior lock value, write-protect level, new lock bit and a protect, unprotect or neutral field. A design that looked at the new lock value instead of the prior one, or let the pin block a lock set, gives wrong pulse counts or a wrong read-back there. Aborted frames are cut at different bit counts: inside the opcode of a status write, where a design that clears the latch too early is caught, and inside its data byte, where a design that commits partial data is caught. A status read with the busy input dropped mid-byte shows whether the block takes a fresh copy at each byte boundary or mixes old and new bits within one byte. A trailing zero byte after a lock set checks that later bytes are discarded.

// File: rtl/spiStatusPkg.sv
package spiStatusPkg;

  // Strobes from the control module to the datapath, one system clock wide.
  typedef struct packed {
    logic frameStart;  // chip-select just went low
    logic frameEnd;    // chip-select just went high
    logic sampleBit;   // rising serial clock inside a frame
    logic driveBit;    // falling serial clock inside a frame
  } spiStrobe_t;

  // The meaningful fields of a status-write data byte.
  typedef struct packed {
    logic       newLock;   // becomes the lock bit
    logic [3:0] field;     // global protect / unprotect selector
  } wrData_t;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] CMD_WR_ENABLE = 8'h06;
  localparam logic [BYTE_W-1:0] CMD_RD_STATUS = 8'h05;
  localparam logic [BYTE_W-1:0] CMD_WR_STATUS = 8'h01;

  localparam logic [3:0] FIELD_PROTECT   = 4'b1111;
  localparam logic [3:0] FIELD_UNPROTECT = 4'b0000;

endpackage

// File: rtl/spiSync.sv
module spiSync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  // STAGES must be at least 2.
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/spiStatusDatapath.sv
module spiStatusDatapath
  import spiStatusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSi,
  input  spiStrobe_t        strobe,
  input  logic              csActive,
  input  logic [BYTE_W-1:0] statusByte,
  output logic [BYTE_W-1:0] opcode,
  output wrData_t           wrData,
  output logic [1:0]        byteCount,
  output logic              spiSo,
  output logic              spiSoEn
);

  logic                 siSync;
  logic [BYTE_W-2:0]    rxShift;
  logic [BYTE_W-1:0]    rxNext;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0]    snap;
  logic                 soReg;
  logic                 readActive;
  logic                 lastBit;

  // Same depth as the clock and select synchronizers keeps data aligned.
  spiSync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RESET_VAL(1'b0)) uSiSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (spiSi),
    .dout (siSync)
  );

  assign rxNext     = {rxShift, siSync};
  assign lastBit    = (bitCnt == BIT_CNT_W'(BYTE_W - 1));
  assign readActive = (opcode == CMD_RD_STATUS) && (byteCount != 2'd0);

  // Receive side: shifter, bit counter, saturating byte counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      bitCnt    <= '0;
      byteCount <= '0;
      opcode    <= '0;
      wrData    <= '0;
    end else if (strobe.frameStart) begin
      rxShift   <= '0;
      bitCnt    <= '0;
      byteCount <= '0;
      opcode    <= '0;
    end else if (strobe.sampleBit) begin
      rxShift <= rxNext[BYTE_W-2:0];
      bitCnt  <= bitCnt + 1'b1;
      if (lastBit) begin
        if (byteCount == 2'd0) opcode <= rxNext;
        if (byteCount == 2'd1) wrData <= '{newLock: rxNext[7], field: rxNext[5:2]};
        if (byteCount != 2'd2) byteCount <= byteCount + 2'd1;
      end
    end
  end

  // Transmit side: a fresh status copy at every byte boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snap  <= '0;
      soReg <= 1'b0;
    end else if (strobe.frameStart || strobe.frameEnd) begin
      soReg <= 1'b0;
    end else if (strobe.driveBit) begin
      if (!readActive) begin
        soReg <= 1'b0;
      end else if (bitCnt == '0) begin
        snap  <= statusByte;
        soReg <= statusByte[BYTE_W-1];
      end else begin
        soReg <= snap[BIT_CNT_W'(BYTE_W - 1) - bitCnt];
      end
    end
  end

  assign spiSo   = soReg;
  assign spiSoEn = csActive;

endmodule

// File: rtl/spiStatusControl.sv
module spiStatusControl
  import spiStatusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiCsN,
  input  logic              spiSck,
  input  logic              wpN,
  input  logic [BYTE_W-1:0] opcode,
  input  wrData_t           wrData,
  input  logic [1:0]        byteCount,
  output spiStrobe_t        strobe,
  output logic              csActive,
  output logic              wel,
  output logic              lockBit,
  output logic              globalProtect,
  output logic              globalUnprotect
);

  logic csSync, sckSync, wpSync;
  logic csActivePrev, sckPrev;
  logic wpActive;
  logic welNext, lockNext, protectNext, unprotectNext;
  logic writeBlocked;

  spiSync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RESET_VAL(3'b101)) uPinSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({spiCsN, spiSck, wpN}),
    .dout ({csSync, sckSync, wpSync})
  );

  assign csActive = ~csSync;
  assign wpActive = ~wpSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csActivePrev <= 1'b0;
      sckPrev      <= 1'b0;
    end else begin
      csActivePrev <= csActive;
      sckPrev      <= sckSync;
    end
  end

  always_comb begin
    strobe.frameStart = csActive & ~csActivePrev;
    strobe.frameEnd   = ~csActive & csActivePrev;
    strobe.sampleBit  = csActive & sckSync & ~sckPrev;
    strobe.driveBit   = csActive & ~sckSync & sckPrev;
  end

  // The pin only blocks an attempt to clear a set lock bit.
  assign writeBlocked = wpActive && lockBit && !wrData.newLock;

  // Commit or abort, decided only when the frame closes.
  always_comb begin
    welNext       = wel;
    lockNext      = lockBit;
    protectNext   = 1'b0;
    unprotectNext = 1'b0;
    if (strobe.frameEnd && byteCount != 2'd0) begin
      case (opcode)
        CMD_WR_ENABLE: welNext = 1'b1;
        CMD_WR_STATUS: begin
          if (wel) begin
            welNext = 1'b0;
            if (byteCount == 2'd2 && !writeBlocked) begin
              lockNext = wrData.newLock;
              if (!lockBit) begin
                protectNext   = (wrData.field == FIELD_PROTECT);
                unprotectNext = (wrData.field == FIELD_UNPROTECT);
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel             <= 1'b0;
      lockBit         <= 1'b0;
      globalProtect   <= 1'b0;
      globalUnprotect <= 1'b0;
    end else begin
      wel             <= welNext;
      lockBit         <= lockNext;
      globalProtect   <= protectNext;
      globalUnprotect <= unprotectNext;
    end
  end

endmodule

// File: rtl/spiFlashStatusCtrl.sv
module spiFlashStatusCtrl
  import spiStatusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiCsN,
  input  logic spiSck,
  input  logic spiSi,
  input  logic wpN,
  input  logic busyIn,
  output logic spiSo,
  output logic spiSoEn,
  output logic globalProtect,
  output logic globalUnprotect
);

  spiStrobe_t        strobe;
  logic              csActive;
  logic              wel;
  logic              lockBit;
  logic [BYTE_W-1:0] opcode;
  wrData_t           wrData;
  logic [1:0]        byteCount;
  logic [BYTE_W-1:0] statusByte;

  assign statusByte = {lockBit, 5'b00000, wel, busyIn};

  spiStatusControl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk             (clk),
    .rstN            (rstN),
    .spiCsN          (spiCsN),
    .spiSck          (spiSck),
    .wpN             (wpN),
    .opcode          (opcode),
    .wrData          (wrData),
    .byteCount       (byteCount),
    .strobe          (strobe),
    .csActive        (csActive),
    .wel             (wel),
    .lockBit         (lockBit),
    .globalProtect   (globalProtect),
    .globalUnprotect (globalUnprotect)
  );

  spiStatusDatapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .spiSi      (spiSi),
    .strobe     (strobe),
    .csActive   (csActive),
    .statusByte (statusByte),
    .opcode     (opcode),
    .wrData     (wrData),
    .byteCount  (byteCount),
    .spiSo      (spiSo),
    .spiSoEn    (spiSoEn)
  );

endmodule

// File: rtl/spiFlashStatusChecker.sv
module spiFlashStatusChecker (
  input logic clk,
  input logic rstN,
  input logic csActive,
  input logic frameEnd,
  input logic wel,
  input logic lockBit,
  input logic globalProtect,
  input logic globalUnprotect
);

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({globalProtect, globalUnprotect}));

  p_protect_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    globalProtect |=> !globalProtect);

  p_unprotect_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    globalUnprotect |=> !globalUnprotect);

  // A pulse only follows an accepted write, which consumed the latch.
  p_pulse_consumes_wel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (globalProtect || globalUnprotect) |-> (!wel && $past(wel)));

  p_pulse_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (globalProtect || globalUnprotect) |-> !csActive);

  p_wel_at_frame_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wel) |-> $past(frameEnd));

  p_lock_at_frame_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockBit) |-> $past(frameEnd));

endmodule

bind spiFlashStatusCtrl spiFlashStatusChecker u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .csActive        (csActive),
  .frameEnd        (strobe.frameEnd),
  .wel             (wel),
  .lockBit         (lockBit),
  .globalProtect   (globalProtect),
  .globalUnprotect (globalUnprotect)
);

// File: tb/sim_spiFlashStatusCtrl.sv
`timescale 1ns/1ps
module sim_spiFlashStatusCtrl;

  localparam int HALF = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiCsN = 1'b1, spiSck = 1'b0, spiSi = 1'b0, wpN = 1'b1, busyIn = 1'b0;
  logic spiSo, spiSoEn, globalProtect, globalUnprotect;

  int tests = 0, fails = 0;
  int protCnt = 0, unprotCnt = 0;
  int busyDropAt = -1;
  bit finished = 0;
  logic soEnMid;
  logic [7:0] txBuf [4];
  logic [7:0] rxBuf [4];
  logic mWel = 1'b0, mLock = 1'b0, wpOn = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  spiFlashStatusCtrl u0 (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSck(spiSck), .spiSi(spiSi),
    .wpN(wpN), .busyIn(busyIn), .spiSo(spiSo), .spiSoEn(spiSoEn),
    .globalProtect(globalProtect), .globalUnprotect(globalUnprotect)
  );

  always @(negedge clk) begin
    if (globalProtect)   protCnt++;
    if (globalUnprotect) unprotCnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runFrame(input int nBits);
    spiCsN = 1'b0;
    tick(HALF);
    for (int i = 0; i < nBits; i++) begin
      if (i == busyDropAt) busyIn = 1'b0;
      spiSi = txBuf[i/8][7 - (i%8)];
      tick(HALF);
      rxBuf[i/8][7 - (i%8)] = spiSo;
      if (i == 0) soEnMid = spiSoEn;
      spiSck = 1'b1;
      tick(HALF);
      spiSck = 1'b0;
    end
    tick(HALF);
    spiCsN = 1'b1;
    spiSi = 1'b0;
    tick(2*HALF);
  endtask

  task automatic readStatus(output logic [7:0] s);
    txBuf[0] = 8'h05;
    runFrame(16);
    s = rxBuf[1];
  endtask

  task automatic checkStatus(input string req);
    logic [7:0] s;
    readStatus(s);
    chk(req, s, {mLock, 5'b0, mWel, busyIn});
  endtask

  task automatic wren();
    txBuf[0] = 8'h06;
    runFrame(8);
    mWel = 1'b1;
  endtask

  // Status write of nBits total (opcode included), checked against the model.
  task automatic wrsr(input logic [7:0] d, input int nBits, input string req);
    int p0, u0c, expP, expU;
    expP = 0; expU = 0;
    p0 = protCnt; u0c = unprotCnt;
    if (mWel && nBits >= 8) begin
      mWel = 1'b0;
      if (nBits >= 16 && !(wpOn && mLock && !d[7])) begin
        if (!mLock) begin
          expP = (d[5:2] == 4'hF) ? 1 : 0;
          expU = (d[5:2] == 4'h0) ? 1 : 0;
        end
        mLock = d[7];
      end
    end
    txBuf[0] = 8'h01;
    txBuf[1] = d;
    runFrame(nBits);
    chk({req, " protect pulses"}, protCnt - p0, expP);
    chk({req, " unprotect pulses"}, unprotCnt - u0c, expU);
    checkStatus({req, " status"});
  endtask

  task automatic setWp(input logic on);
    wpOn = on;
    wpN = ~on;
    tick(4);
  endtask

  initial begin
    logic [7:0] s;
    logic [3:0] fields [3];
    fields[0] = 4'hF; fields[1] = 4'h0; fields[2] = 4'h5;
    for (int i = 0; i < 4; i++) begin txBuf[i] = '0; rxBuf[i] = '0; end

    tick(5);
    rstN = 1'b1;
    tick(5);

    // R1: reset state
    chk("R1 soEn idle", spiSoEn, 1'b0);
    chk("R1 no pulses", protCnt + unprotCnt, 0);
    checkStatus("R1 status after reset");

    // R9: output enable follows chip-select
    chk("R9 soEn during frame", soEnMid, 1'b1);
    chk("R9 soEn after frame", spiSoEn, 1'b0);

    // R2: incomplete write enable leaves latch clear
    txBuf[0] = 8'h06; runFrame(5);
    checkStatus("R2 partial 06h");
    // R2: complete write enable
    wren();
    checkStatus("R2 write enable");
    // R2: partial status-write opcode keeps latch
    txBuf[0] = 8'h01; runFrame(6);
    checkStatus("R2 partial 01h keeps latch");
    // R2: unrecognised opcode keeps latch
    txBuf[0] = 8'h9F; runFrame(8);
    checkStatus("R2 unknown opcode keeps latch");

    // R3: repeating status read with a busy change mid-byte
    busyIn = 1'b1;
    busyDropAt = 12;
    txBuf[0] = 8'h05;
    runFrame(32);
    busyDropAt = -1;
    chk("R3 first status byte", rxBuf[1], {mLock, 5'b0, mWel, 1'b1});
    chk("R3 repeated byte shows busy cleared", rxBuf[2], {mLock, 5'b0, mWel, 1'b0});
    chk("R3 third byte", rxBuf[3], {mLock, 5'b0, mWel, 1'b0});

    // R5: status write without the latch
    setWp(1'b0);
    mWel = 1'b0;
    txBuf[0] = 8'h04; runFrame(0);  // no-op frame
    wren();
    wrsr(8'h80, 16, "R4 set lock");
    wrsr(8'h3C, 16, "R5 write without latch");

    // R6: data byte cut short
    wren();
    wrsr(8'h3C, 12, "R6 aborted data");

    // R4: trailing byte ignored
    wren();
    wrsr(8'h00, 16, "R4 clear lock");
    wren();
    txBuf[2] = 8'h00;
    wrsr(8'hBC, 24, "R4 extra byte ignored");

    // R7/R8: sweep prior lock, pin, new lock and field
    for (int pl = 0; pl < 2; pl++)
      for (int wp = 0; wp < 2; wp++)
        for (int nl = 0; nl < 2; nl++)
          for (int f = 0; f < 3; f++) begin
            setWp(1'b0);
            wren();
            wrsr({pl[0], 1'b0, 4'h5, 2'b00}, 16, "R8 setup");
            setWp(wp[0]);
            wren();
            wrsr({nl[0], 1'b1, fields[f], 2'b11}, 16,
                 (wp != 0) ? "R7 write under pin" : "R8 sweep write");
          end

    // R8: pulse width seen via counter per accepted write
    setWp(1'b0);
    wren(); wrsr(8'h00, 16, "R8 unlock");
    wren(); wrsr(8'h3C, 16, "R8 global protect");
    readStatus(s);
    chk("R9 soEn idle at end", spiSoEn, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule